// File: doc/BRIEF.md
# Bus Ownership Handover Controller

This block sits beside a processor's bus interface and hands the external bus to another master, such as a DMA engine, on request. Three active-low wires carry the exchange. The requester pulls a request line. The controller answers on a grant line. The new master then confirms on an acknowledge line that it now owns the bus. The controller also drives an output enable for the processor's address, data and control drivers. That enable is removed as soon as the grant goes out, which leaves the wires free for the other master.

A grant is never issued in the middle of a processor bus cycle. While the processor's address strobe is active, a pending request waits. Once the acknowledge arrives, the grant line is released and the acknowledge alone holds the processor off the bus. The processor takes the bus back only when both the acknowledge and the request are inactive. A request that is withdrawn before any acknowledge simply cancels the grant.

All inputs are sampled on the rising clock edge, and both outputs come straight from the state register. Every response therefore appears one clock after the edge that sampled its cause.

Top module: `bus_handover`

## Requirements
- R1: While reset is active, and on leaving reset, `bus_grant_n` is 1 and `drv_oe` is 1, which means the processor owns the bus.
- R2: When `bus_req_n` is 0 and `cyc_active` is 0 at a rising edge while the processor owns the bus, `bus_grant_n` becomes 0 and `drv_oe` becomes 0 after that edge.
- R3: While `cyc_active` is 1, no grant is issued whatever `bus_req_n` is. A held request is granted one edge after the edge that samples `cyc_active` at 0.
- R4: In the granted state, an edge that samples `grant_ack_n` at 0 sets `bus_grant_n` back to 1 and keeps `drv_oe` at 0.
- R5: Once the acknowledge has been seen, `drv_oe` stays 0 for as long as `grant_ack_n` is 0, whatever `bus_req_n` and `cyc_active` do.
- R6: After the acknowledge has been seen, `drv_oe` returns to 1 only after an edge that samples both `grant_ack_n` and `bus_req_n` at 1. It stays 0 if either of them is still 0.
- R7: In the granted state, if an edge samples `bus_req_n` at 1 and `grant_ack_n` at 1, the grant is withdrawn: `bus_grant_n` becomes 1 and `drv_oe` becomes 1.
- R8: In the granted state, if the request is withdrawn at the same edge that samples the acknowledge at 0, the acknowledge wins and the bus stays released (`bus_grant_n` 1, `drv_oe` 0).
- R9: An acknowledge (`grant_ack_n` at 0) that arrives while no grant is outstanding and no request is pending has no effect: both outputs stay at 1.
- R10: `bus_grant_n` is never 0 while `drv_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Bus request from the external master, active low |
| cyc_active | input | 1 | High while the processor's address strobe is asserted (bus cycle in progress) |
| grant_ack_n | input | 1 | Grant acknowledge from the new master, active low |
| bus_grant_n | output | 1 | Bus grant to the external master, active low |
| drv_oe | output | 1 | Enable for the processor's address, data and control drivers; 0 means high impedance |

## Verification
Each output reacts exactly one rising edge after the edge that samples its cause. No response takes zero cycles or more than one. The bench therefore changes inputs on the falling edge and reads the outputs on the next falling edge, half a period after the single rising edge in between. For the held-off grant, the check is made on each falling edge while the strobe is high, and again one edge after the strobe drops. Every reachable state (processor owner, granted, released) is set up from reset, and all eight combinations of the three inputs are applied to it, so each next-state arc is checked on its own one-cycle window.

// File: rtl/bus_handover.sv
module bus_handover (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_n,
  input  logic cyc_active,
  input  logic grant_ack_n,
  output logic bus_grant_n,
  output logic drv_oe
);

  typedef enum logic [1:0] {
    CPU_OWNS = 2'd0,
    GRANTED  = 2'd1,
    RELEASED = 2'd2
  } own_t;

  own_t st, st_nx;

  wire want = ~bus_req_n;
  wire held = ~grant_ack_n;

  always_comb begin
    st_nx = st;
    unique case (st)
      CPU_OWNS: if (want && !cyc_active) st_nx = GRANTED;
      GRANTED:  if (held)                st_nx = RELEASED;
                else if (!want)          st_nx = CPU_OWNS;
      RELEASED: if (!held && !want)      st_nx = CPU_OWNS;
      default:                           st_nx = CPU_OWNS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= CPU_OWNS;
    else        st <= st_nx;

  assign bus_grant_n = (st != GRANTED);
  assign drv_oe      = (st == CPU_OWNS);

endmodule

module bus_handover_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req_n,
  input logic cyc_active,
  input logic grant_ack_n,
  input logic bus_grant_n,
  input logic drv_oe
);

  assert_grant_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> ($past(!cyc_active) && $past(!bus_req_n)));

  assert_ack_drops_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_n && !grant_ack_n) |=> (bus_grant_n && !drv_oe));

  assert_ack_holds_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_oe && !grant_ack_n) |=> !drv_oe);

  assert_return_needs_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_oe) |-> ($past(bus_req_n) && $past(grant_ack_n)));

  assert_cancel_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_n && bus_req_n && grant_ack_n) |=> (bus_grant_n && drv_oe));

  assert_stray_ack_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_oe && bus_req_n && !grant_ack_n) |=> (drv_oe && bus_grant_n));

  always @(negedge clk)
    if (rst_n) assert_no_grant_on_bus_R10: assert (!(drv_oe && !bus_grant_n));

endmodule

bind bus_handover bus_handover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .cyc_active(cyc_active),
  .grant_ack_n(grant_ack_n), .bus_grant_n(bus_grant_n), .drv_oe(drv_oe)
);

// File: tb/tb_bus_handover.sv
module tb_bus_handover;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req_n = 1'b1;
  logic cyc_active = 1'b0;
  logic grant_ack_n = 1'b1;
  logic bus_grant_n, drv_oe;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_handover dut (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .cyc_active(cyc_active),
    .grant_ack_n(grant_ack_n), .bus_grant_n(bus_grant_n), .drv_oe(drv_oe)
  );

  task automatic check(input string req, input logic [1:0] exp);
    n_chk++;
    if ({bus_grant_n, drv_oe} !== exp) begin
      n_bad++;
      $display("FAIL %s: {grant_n,oe} actual %b expected %b at %0t", req, {bus_grant_n, drv_oe}, exp, $time);
    end
  endtask

  task automatic step(input logic rq, input logic ak, input logic bz);
    bus_req_n = rq; grant_ack_n = ak; cyc_active = bz;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_req_n = 1'b1; grant_ack_n = 1'b1; cyc_active = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [1:0] model(input int s, input logic rq, input logic ak, input logic bz);
    case (s)
      0: return (!rq && !bz) ? 2'b00 : 2'b11;
      1: return !ak ? 2'b10 : (rq ? 2'b11 : 2'b00);
      default: return (ak && rq) ? 2'b11 : 2'b10;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1 in reset", 2'b11);
    do_reset();
    check("R1 after reset", 2'b11);

    step(1'b0, 1'b1, 1'b0);
    check("R2 grant next edge", 2'b00);
    step(1'b0, 1'b0, 1'b0);
    check("R4 ack drops grant", 2'b10);
    step(1'b1, 1'b0, 1'b1);
    check("R5 ack holds bus", 2'b10);
    step(1'b0, 1'b1, 1'b0);
    check("R6 request still low", 2'b10);
    step(1'b1, 1'b1, 1'b0);
    check("R6 both released", 2'b11);

    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 1'b1);
      check("R3 held off during cycle", 2'b11);
    end
    step(1'b0, 1'b1, 1'b0);
    check("R3 granted after cycle ends", 2'b00);
    step(1'b1, 1'b1, 1'b0);
    check("R7 cancel before ack", 2'b11);

    step(1'b0, 1'b1, 1'b0);
    check("R2 second grant", 2'b00);
    step(1'b1, 1'b0, 1'b0);
    check("R8 ack beats withdrawal", 2'b10);
    step(1'b1, 1'b1, 1'b0);
    check("R6 return", 2'b11);

    step(1'b1, 1'b0, 1'b0);
    check("R9 stray ack", 2'b11);
    step(1'b1, 1'b0, 1'b1);
    check("R9 stray ack during cycle", 2'b11);

    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 8; v++) begin
        logic rq, ak, bz;
        {rq, ak, bz} = v[2:0];
        do_reset();
        if (s >= 1) step(1'b0, 1'b1, 1'b0);
        if (s == 2) step(1'b0, 1'b0, 1'b0);
        step(rq, ak, bz);
        case (s)
          0: check("R3 sweep from owner", model(s, rq, ak, bz));
          1: check("R8 sweep from granted", model(s, rq, ak, bz));
          default: check("R6 sweep from released", model(s, rq, ak, bz));
        endcase
        if (!bus_grant_n && drv_oe) begin
          n_chk++; n_bad++;
          $display("FAIL R10: actual grant with oe expected never");
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule